// File: doc/BRIEF.md
# Linear Frequency Ramp Generator

This block slews a frequency control word from a start value to a target value along a straight line. The start value is typically the frequency held while no reference was usable. The target is the frequency of a newly acquired or newly selected input clock. A single strobe captures both words and a rate index. The block then measures how far apart the two words are. From that distance and the chosen step size it derives how many ticks the ramp must last. It then moves the output one step per tick, up or down as the sign of the difference requires.

The step size comes from an indexed table of 40 rates. The rates are spaced geometrically, from a few LSBs per tick up to several thousand. The tick enable sets the physical rate in ppm per second, and it is kept separate from any loop-filter setting. The last step is shortened when needed, so the output lands exactly on the target and never passes it. The same sequence serves both leaving holdover and ramped switching from one input clock to another.

Top module: `freq_ramp_gen`

## Requirements
- R1: A synchronous active-low reset sets freq_o to 0 and clears busy_o and done_o, including in the middle of a ramp.
- R2: A start strobe sampled while busy_o is low loads freq_o with start_word_i on that edge. When the two words differ, busy_o is high from the next cycle.
- R3: The step per tick for index k in 0..39 is (4 + k mod 4) shifted left by (k div 4) LSBs. Any index of 40 or more uses index 39.
- R4: The number of times freq_o changes during a ramp equals ceil(|target − start| / step).
- R5: Each change moves freq_o toward the target by exactly one step. Only the final change may be shorter. freq_o never passes the target.
- R6: On the final step, freq_o takes the target value exactly. In that same cycle busy_o falls and done_o is high for one cycle.
- R7: When the start and target words are equal, done_o is high in the cycle after the strobe. busy_o stays low and freq_o equals the start word.
- R8: freq_o changes only on an edge where tick_en_i is high and the ramp is stepping. Ticks during the duration computation are not counted.
- R9: A start strobe while busy_o is high is ignored, including on the edge of the final step. The ramp in progress ends on its own target.
- R10: A start strobe in the cycle where done_o is high is accepted as a new ramp.
- R11: The start word, target word and rate index are sampled only at an accepted strobe. Later changes to them have no effect on the ramp in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Start strobe |
| start_word_i | input | FW | Frequency word at the beginning of the ramp |
| target_word_i | input | FW | Frequency word to land on |
| rate_sel_i | input | IDXW | Rate table index |
| tick_en_i | input | 1 | Step enable, one step per high cycle |
| freq_o | output | FW | Current frequency control word |
| busy_o | output | 1 | Ramp computing or stepping |
| done_o | output | 1 | One-cycle pulse when the ramp has ended |

## Verification
Two events can meet on one edge: the final step of a ramp and a new start strobe. To provoke this, the bench holds start_i high, with different words, for the whole of a ramp. The strobe is therefore present on the edge that lands on the target. The bench judges that this strobe was ignored: done_o pulses, freq_o equals the original target, and busy_o stays low afterwards. The opposite ordering is also tested. Back-to-back ramps place the next strobe in the done_o cycle, and that strobe must be accepted.

// File: rtl/ramp_pkg.sv
// Shared types and the rate law for the frequency ramp generator.
// Assumes rate indices are small non-negative integers.
package ramp_pkg;

    typedef enum logic [1:0] {
        RS_IDLE = 2'd0,
        RS_SPAN = 2'd1,
        RS_SLEW = 2'd2
    } ramp_state_t;

    // Step size in LSBs per tick for a (clamped) rate index: mantissa 4..7, exponent idx/4.
    function automatic logic [31:0] rate_step(input int idx);
        int mant;
        int expo;
        mant = 4 + (idx % 4);
        expo = idx / 4;
        return 32'(mant) << expo;
    endfunction

endpackage

// File: rtl/ramp_rate_lut.sv
// Maps a rate index to a step size in frequency-word LSBs.
// Entries beyond NRATES-1 repeat the last valid rate (clamp).
// Assumes SW is wide enough for the largest step of the table.
module ramp_rate_lut
    import ramp_pkg::*;
#(
    parameter int IDXW   = 6,
    parameter int SW     = 16,
    parameter int NRATES = 40
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [IDXW-1:0] sel_i,
    output logic [SW-1:0]   step_o
);

    localparam int DEPTH = 1 << IDXW;

    logic [SW-1:0] tbl [DEPTH];

    // One table entry per index, computed at elaboration.
    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        localparam int          CL  = (g < NRATES) ? g : NRATES - 1;
        localparam logic [31:0] RAW = rate_step(CL);
        assign tbl[g] = RAW[SW-1:0];
    end

    assign step_o = tbl[sel_i];

    AST_STEP_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        step_o >= SW'(4)); // R3

endmodule

// File: rtl/ramp_span_div.sv
// Sequential restoring divider giving the ramp duration in ticks:
// ceil(dividend / divisor). Takes FW cycles after load, then pulses valid_o.
// Assumes divisor_i is non-zero and fits in SW bits.
module ramp_span_div #(
    parameter int FW = 32,
    parameter int SW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [FW-1:0] dividend_i,
    input  logic [SW-1:0] divisor_i,
    output logic          valid_o,
    output logic [FW-1:0] quot_o
);

    localparam int CW = $clog2(FW + 1);

    logic [FW-1:0] quo_q;
    logic [SW-1:0] rem_q;
    logic [SW-1:0] dvs_q;
    logic [CW-1:0] cnt_q;
    logic          run_q;
    logic          valid_q;
    logic [SW:0]   trial_w;
    logic [SW-1:0] diff_w;
    logic          fit_w;

    // Partial remainder with the next dividend bit shifted in, and trial subtraction.
    always_comb begin
        trial_w = {rem_q, quo_q[FW-1]};
        fit_w   = trial_w >= {1'b0, dvs_q};
        diff_w  = trial_w[SW-1:0] - dvs_q;
    end

    // One quotient bit per cycle; valid pulses after the last bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quo_q   <= '0;
            rem_q   <= '0;
            dvs_q   <= '0;
            cnt_q   <= '0;
            run_q   <= 1'b0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (load_i) begin
                quo_q <= dividend_i;
                rem_q <= '0;
                dvs_q <= divisor_i;
                cnt_q <= '0;
                run_q <= 1'b1;
            end else if (run_q) begin
                quo_q <= {quo_q[FW-2:0], fit_w};
                rem_q <= fit_w ? diff_w : trial_w[SW-1:0];
                cnt_q <= cnt_q + 1'b1;
                if (cnt_q == CW'(FW - 1)) begin
                    run_q   <= 1'b0;
                    valid_q <= 1'b1;
                end
            end
        end
    end

    assign valid_o = valid_q;
    assign quot_o  = quo_q + {{(FW-1){1'b0}}, |rem_q};

    AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |-> (rem_q < dvs_q)); // R4

endmodule

// File: rtl/ramp_slew_acc.sv
// Output accumulator: holds the frequency word, steps it by a signed amount
// once per tick for a preset number of ticks, and forces the last tick onto
// the target so the ramp lands exactly without overshoot.
// Assumes count_i >= 1 whenever armed and that step/target/direction are held.
module ramp_slew_acc #(
    parameter int FW = 32,
    parameter int SW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [FW-1:0] load_word_i,
    input  logic          arm_i,
    input  logic [FW-1:0] count_i,
    input  logic          tick_i,
    input  logic [SW-1:0] step_i,
    input  logic          down_i,
    input  logic [FW-1:0] target_i,
    output logic [FW-1:0] freq_o,
    output logic          last_o
);

    logic [FW-1:0] freq_q;
    logic [FW-1:0] remain_q;
    logic [FW-1:0] step_x;

    assign step_x = {{(FW-SW){1'b0}}, step_i};
    assign last_o = tick_i && (remain_q == FW'(1));

    // Load, arm, step or land the frequency word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            freq_q   <= '0;
            remain_q <= '0;
        end else if (load_i) begin
            freq_q   <= load_word_i;
            remain_q <= '0;
        end else if (arm_i) begin
            remain_q <= count_i;
        end else if (last_o) begin
            freq_q   <= target_i;
            remain_q <= '0;
        end else if (tick_i && (remain_q != '0)) begin
            freq_q   <= down_i ? (freq_q - step_x) : (freq_q + step_x);
            remain_q <= remain_q - 1'b1;
        end
    end

    assign freq_o = freq_q;

    AST_NO_EARLY_LAND: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && (remain_q > FW'(1))) |=> (freq_q != target_i)); // R5

    AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !load_i) |=> $stable(freq_q)); // R8

endmodule

// File: rtl/freq_ramp_gen.sv
// Linear frequency ramp generator, top level.
// On an accepted start it captures the words, takes the magnitude and sign of
// their difference, divides the magnitude by the selected step to get the
// duration, then steps the output once per tick until it lands on the target.
// Assumes tick_en_i is a single-cycle-per-step enable in the clk domain.
module freq_ramp_gen
    import ramp_pkg::*;
#(
    parameter int FW     = 32,
    parameter int SW     = 16,
    parameter int IDXW   = 6,
    parameter int NRATES = 40
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [FW-1:0]   start_word_i,
    input  logic [FW-1:0]   target_word_i,
    input  logic [IDXW-1:0] rate_sel_i,
    input  logic            tick_en_i,
    output logic [FW-1:0]   freq_o,
    output logic            busy_o,
    output logic            done_o
);

    ramp_state_t   st_q;
    logic [FW-1:0] tgt_q;
    logic [SW-1:0] step_q;
    logic          down_q;
    logic          done_q;

    logic [SW-1:0] step_w;
    logic          down_w;
    logic [FW-1:0] mag_w;
    logic          zero_w;
    logic          accept_w;
    logic          div_valid_w;
    logic [FW-1:0] ticks_w;
    logic          tick_w;
    logic          last_w;

    assign busy_o   = (st_q != RS_IDLE);
    assign accept_w = start_i && !busy_o;
    assign tick_w   = tick_en_i && (st_q == RS_SLEW);

    // Difference measured at the strobe: direction and magnitude.
    always_comb begin
        down_w = start_word_i > target_word_i;
        mag_w  = down_w ? (start_word_i - target_word_i)
                        : (target_word_i - start_word_i);
        zero_w = (mag_w == '0);
    end

    ramp_rate_lut #(
        .IDXW   (IDXW),
        .SW     (SW),
        .NRATES (NRATES)
    ) u_lut (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel_i  (rate_sel_i),
        .step_o (step_w)
    );

    ramp_span_div #(
        .FW (FW),
        .SW (SW)
    ) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (accept_w && !zero_w),
        .dividend_i (mag_w),
        .divisor_i  (step_w),
        .valid_o    (div_valid_w),
        .quot_o     (ticks_w)
    );

    ramp_slew_acc #(
        .FW (FW),
        .SW (SW)
    ) u_acc (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (accept_w),
        .load_word_i (start_word_i),
        .arm_i       ((st_q == RS_SPAN) && div_valid_w),
        .count_i     (ticks_w),
        .tick_i      (tick_w),
        .step_i      (step_q),
        .down_i      (down_q),
        .target_i    (tgt_q),
        .freq_o      (freq_o),
        .last_o      (last_w)
    );

    // Sequence: idle -> duration computation -> stepping -> idle with done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= RS_IDLE;
            tgt_q  <= '0;
            step_q <= '0;
            down_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (st_q)
                RS_IDLE: begin
                    if (accept_w) begin
                        tgt_q  <= target_word_i;
                        step_q <= step_w;
                        down_q <= down_w;
                        if (zero_w) begin
                            done_q <= 1'b1;
                        end else begin
                            st_q <= RS_SPAN;
                        end
                    end
                end
                RS_SPAN: begin
                    if (div_valid_w) begin
                        st_q <= RS_SLEW;
                    end
                end
                RS_SLEW: begin
                    if (last_w) begin
                        st_q   <= RS_IDLE;
                        done_q <= 1'b1;
                    end
                end
                default: st_q <= RS_IDLE;
            endcase
        end
    end

    assign done_o = done_q;

    AST_LAND_ON_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (freq_o == tgt_q)); // R6

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o); // R6

    AST_ZERO_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && (start_word_i == target_word_i)) |=> (done_o && !busy_o)); // R7

    AST_BUSY_START_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && busy_o && !last_w) |=> busy_o); // R9

endmodule

// File: tb/freq_ramp_gen_test.sv
// Self-checking bench for freq_ramp_gen: a vector table walked by one loop,
// then directed tests for reset, collisions and input changes mid-ramp.
module freq_ramp_gen_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] start_word_i = '0;
    logic [31:0] target_word_i = '0;
    logic [5:0]  rate_sel_i = '0;
    logic        tick_en_i = 1'b0;
    logic [31:0] freq_o;
    logic        busy_o;
    logic        done_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    // Vector: {start word, target word, rate index, tick divider}
    localparam logic [71:0] VEC [8] = '{
        {32'd1000,       32'd1100,       6'd0,  2'd1},
        {32'd5000,       32'd4000,       6'd5,  2'd1},
        {32'd100,        32'd203,        6'd2,  2'd3},
        {32'hFFFF_F000,  32'hFFFF_FFFF,  6'd39, 2'd1},
        {32'd70000,      32'd10,         6'd63, 2'd2},
        {32'h8000_0000,  32'h7FFF_FFF0,  6'd12, 2'd1},
        {32'd300,        32'd300,        6'd7,  2'd1},
        {32'd12345,      32'd20000,      6'd20, 2'd3}
    };

    freq_ramp_gen uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .start_word_i  (start_word_i),
        .target_word_i (target_word_i),
        .rate_sel_i    (rate_sel_i),
        .tick_en_i     (tick_en_i),
        .freq_o        (freq_o),
        .busy_o        (busy_o),
        .done_o        (done_o)
    );

    always #10 clk = ~clk;

    function automatic longint exp_step(input int idx);
        int c;
        c = (idx > 39) ? 39 : idx;
        return longint'((4 + c % 4) << (c / 4));
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // mode 0: plain; 1: hold strobe with other words during whole ramp; 2: change words without strobe
    task automatic run_ramp(input logic [31:0] s, input logic [31:0] t, input int idx,
                            input int tdiv, input int mode);
        longint mag, st, expn, delta;
        int steps, bad, cyc, first_delta;
        logic [31:0] prev;
        logic tick_prev;
        bit dir_ok;
        mag  = (s > t) ? longint'(s) - longint'(t) : longint'(t) - longint'(s);
        st   = exp_step(idx);
        expn = (mag + st - 1) / st;
        start_i = 1'b1;
        start_word_i = s;
        target_word_i = t;
        rate_sel_i = 6'(idx);
        tick_en_i = 1'b0;
        @(negedge clk);
        check(freq_o == s, "R2 R10 start word loaded", freq_o, s);
        if (mag == 0) begin
            start_i = 1'b0;
            check(done_o && !busy_o, "R7 zero span done", {done_o, busy_o}, 2);
            @(negedge clk);
            check(!busy_o && freq_o == s, "R7 no stepping", freq_o, s);
        end else begin
            check(busy_o, "R2 busy after start", busy_o, 1);
            start_i = (mode == 1);
            if (mode == 1) begin
                start_word_i = s ^ 32'h55;
                target_word_i = ~t;
                rate_sel_i = 6'd0;
            end else if (mode == 2) begin
                start_word_i = ~s;
                target_word_i = t + 7;
                rate_sel_i = 6'd39;
            end
            prev = s; steps = 0; bad = 0; cyc = 0; first_delta = -1;
            while (!done_o && cyc < 20000) begin
                tick_en_i = ((cyc % tdiv) == 0);
                tick_prev = tick_en_i;
                @(negedge clk);
                cyc++;
                if (freq_o != prev) begin
                    steps++;
                    if (t > s) begin
                        dir_ok = (freq_o > prev) && (freq_o <= t);
                        delta = longint'(freq_o) - longint'(prev);
                    end else begin
                        dir_ok = (freq_o < prev) && (freq_o >= t);
                        delta = longint'(prev) - longint'(freq_o);
                    end
                    if (first_delta < 0) first_delta = int'(delta);
                    if (!dir_ok) bad++;
                    if (delta > st) bad++;
                    if (delta != st && freq_o != t) bad++;
                    if (!tick_prev) bad++;
                    prev = freq_o;
                end
            end
            start_i = 1'b0;
            tick_en_i = 1'b0;
            check(done_o, "R6 done pulse seen", done_o, 1);
            check(freq_o == t, "R6 lands on target", freq_o, t);
            check(!busy_o, "R6 busy falls with done", busy_o, 0);
            check(steps == expn, "R4 step count", steps, expn);
            check(bad == 0, "R5 R8 linear toward target, tick gated", bad, 0);
            if (expn > 1) check(first_delta == st, "R3 step size", first_delta, st);
            if (mode == 1) begin
                @(negedge clk);
                check(!busy_o && freq_o == t && !done_o, "R9 strobe on final edge ignored", freq_o, t);
            end
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog R6 actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check(freq_o == 0 && !busy_o && !done_o, "R1 reset state", freq_o, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Vector table: back-to-back ramps put each strobe in the previous done cycle (R10)
        for (int i = 0; i < 8; i++) begin
            run_ramp(VEC[i][71:40], VEC[i][39:8], int'(VEC[i][7:2]), int'(VEC[i][1:0]), 0);
        end

        // R9: strobe held through the whole ramp, including the final-step edge
        @(negedge clk);
        run_ramp(32'd0, 32'd400, 0, 1, 1);

        // R11: input words and index changed after the strobe
        run_ramp(32'd9000, 32'd8000, 8, 2, 2);

        // R3: clamped index equals index 39 in duration
        run_ramp(32'd0, 32'd7168, 45, 1, 0);

        // R1: reset in the middle of a ramp
        start_i = 1'b1; start_word_i = 32'd500; target_word_i = 32'd900; rate_sel_i = 6'd0;
        @(negedge clk);
        start_i = 1'b0; tick_en_i = 1'b1;
        repeat (45) @(negedge clk);
        check(busy_o && freq_o != 32'd500, "R1 precondition ramp stepping", freq_o, 500);
        rst_n = 1'b0;
        @(negedge clk);
        check(freq_o == 0 && !busy_o && !done_o, "R1 mid-ramp reset", freq_o, 0);
        rst_n = 1'b1; tick_en_i = 1'b0;
        repeat (3) @(negedge clk);
        check(freq_o == 0 && !busy_o, "R1 stays idle after reset", freq_o, 0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule